// File: doc/BRIEF.md
# Interrupt Message Translation Walker

This block turns an incoming message-signalled interrupt request into an interrupt that can be routed. Each request carries a device number and an event number. The walker resolves the request through three small local tables, all held in registers:

- A device table, which gives the base slot and the event count of that device's translation region.
- A shared translation pool, indexed by the base slot plus the event number.
- A virtual-processor table, which comes in two banks.

Every translation entry carries a type flag. A physical entry ends the walk with an interrupt number and a collection tag. A virtual entry continues the walk: the virtual processor number indexes the virtual-processor table, which gives the hosting redistributor and the base of that processor's pending store. The virtual result also carries the optional doorbell interrupt number from the translation entry.

The tables are loaded through a write-only configuration port. Requests enter on a valid/ready handshake and results leave on a second valid/ready handshake. Only one request is walked at a time. A mode bit, sampled with the request, chooses between the walker's private virtual-processor bank and the bank shared with the redistributors. Any invalid step ends the walk with an error response that carries no interrupt data.

Top module: `msi_xlate_unit`

## Requirements
- R1: Out of reset, reqReady is 1, rspValid is 0, and every table entry reads as invalid.
- R2: A valid device and a valid translation entry with type bit 0 give a physical response. In that response rspErr=0, rspVirt=0, rspIntid is the entry's number and rspColl is the entry's 8-bit tag. rspVpe, rspRd, rspPend, rspDbValid and rspDoorbell are 0. rspValid rises on the third clock edge after the request is accepted.
- R3: A translation entry with type bit 1 and a valid virtual-processor entry give rspVirt=1, rspIntid, and rspVpe equal to the low 3 bits of the tag. It also gives rspRd and rspPend from the virtual-processor entry, and rspColl=0. rspValid rises on the fourth edge after acceptance.
- R4: rspDoorbell carries the doorbell number only when the translation entry's doorbell-present bit is 1. Otherwise rspDbValid=0 and rspDoorbell=0.
- R5: reqSharedVpe is sampled at acceptance. A value of 1 reads the shared virtual-processor bank and a value of 0 reads the private bank.
- R6: If the device entry is invalid, the response has rspErr=1 and all data fields 0. It appears on the second edge after acceptance.
- R7: An event number that is not below the device's event count is an error, timed as in R6.
- R8: An invalid translation entry gives an error with all data fields 0, on the third edge after acceptance.
- R9: A virtual result whose virtual-processor entry is invalid gives an error with all data fields 0, on the fourth edge after acceptance.
- R10: reqReady stays 0 from the acceptance edge until the response handshake. While rspValid=1 and rspReady=0, every response output holds steady.
- R11: A configuration write takes effect at its clock edge. A table read that the walk latches on that same edge sees the old entry.
- R12: The translation slot is (base + event) modulo 32. The entry encodings on cfgData are as follows.
  - cfgSel=0 writes the device table at cfgAddr[2:0], with valid at bit 0, base at [5:1] and event count at [10:6].
  - cfgSel=1 writes the translation pool at cfgAddr[4:0], with valid at bit 0, type at bit 1, number at [17:2], tag at [25:18], doorbell-present at bit 26 and doorbell at [42:27].
  - cfgSel=2 writes the private bank and cfgSel=3 the shared bank, each at cfgAddr[2:0], with valid at bit 0, redistributor at [3:1] and pending base at [19:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 2 | Table select |
| cfgAddr | input | 5 | Entry index |
| cfgData | input | 43 | Entry contents |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqDev | input | 3 | Device number |
| reqEvt | input | 4 | Event number |
| reqSharedVpe | input | 1 | Selects the shared virtual-processor bank |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response taken |
| rspErr | output | 1 | Walk failed |
| rspVirt | output | 1 | Virtual result |
| rspIntid | output | 16 | Physical or virtual interrupt number |
| rspColl | output | 8 | Collection tag (physical) |
| rspVpe | output | 3 | Virtual processor number |
| rspRd | output | 3 | Hosting redistributor |
| rspPend | output | 16 | Pending-store base |
| rspDbValid | output | 1 | Doorbell present |
| rspDoorbell | output | 16 | Doorbell interrupt number |

## Verification
The two functions that can fall in the same cycle are a configuration write and the walk's read of the entry being rewritten. The bench starts a lookup and times a write that invalidates the selected translation entry so that it lands on the exact edge where the walker latches that entry. It expects the old physical result, then repeats the lookup and expects an error. Response stalls are also exercised, to judge that the outputs hold and that no second request is taken.

// File: rtl/msi_xlate_pkg.sv
package msi_xlate_pkg;
  localparam int DEV_AW  = 3;
  localparam int EVT_W   = 4;
  localparam int ITE_AW  = 5;
  localparam int VPE_AW  = 3;
  localparam int INTID_W = 16;
  localparam int TAG_W   = 8;
  localparam int RD_W    = 3;
  localparam int PEND_W  = 16;
  localparam int DEV_N   = 1 << DEV_AW;
  localparam int ITE_N   = 1 << ITE_AW;
  localparam int VPE_N   = 1 << VPE_AW;
  localparam int BANKS   = 2;
  localparam int CFG_AW  = ITE_AW;

  typedef struct packed {
    logic [EVT_W:0]    count;
    logic [ITE_AW-1:0] base;
    logic              valid;
  } devEnt_t;

  typedef struct packed {
    logic [INTID_W-1:0] doorbell;
    logic               dbValid;
    logic [TAG_W-1:0]   tag;
    logic [INTID_W-1:0] intid;
    logic               virt;
    logic               valid;
  } iteEnt_t;

  typedef struct packed {
    logic [PEND_W-1:0] pend;
    logic [RD_W-1:0]   rd;
    logic              valid;
  } vpeEnt_t;

  localparam int CFG_W = $bits(iteEnt_t);

  typedef struct packed {
    logic               err;
    logic               virt;
    logic [INTID_W-1:0] intid;
    logic [TAG_W-1:0]   coll;
    logic [VPE_AW-1:0]  vpe;
    logic [RD_W-1:0]    rd;
    logic [PEND_W-1:0]  pend;
    logic               dbValid;
    logic [INTID_W-1:0] doorbell;
  } rsp_t;

  typedef struct packed {
    logic capReq;
    logic ldDev;
    logic ldIte;
    logic ldVpe;
    logic setErr;
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_ITE, S_VPE, S_RSP
  } walkState_t;
endpackage

// File: rtl/msi_xlate_data.sv
module msi_xlate_data
  import msi_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [DEV_AW-1:0] reqDev,
  input  logic [EVT_W-1:0]  reqEvt,
  input  logic              reqSharedVpe,
  input  ctl_t              ctl,
  input  logic              rspValid,
  input  logic              rspReady,
  output logic              devOk,
  output logic              iteOk,
  output logic              iteVirt,
  output logic              vpeOk,
  output rsp_t              rspQ
);
  devEnt_t devTab [DEV_N];
  iteEnt_t iteTab [ITE_N];
  vpeEnt_t vpeTab [BANKS][VPE_N];

  logic [DEV_AW-1:0] devQ;
  logic [EVT_W-1:0]  evtQ;
  logic              sharedQ;
  logic [ITE_AW-1:0] iteIdxQ;
  logic [VPE_AW-1:0] vpeIdQ;

  devEnt_t devCur;
  iteEnt_t iteCur;
  vpeEnt_t vpeCur;

  // Table storage; the two virtual-processor banks share one write path.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEV_N; i++) devTab[i] <= '0;
      for (int i = 0; i < ITE_N; i++) iteTab[i] <= '0;
    end else if (cfgWe) begin
      if (cfgSel == 2'd0) devTab[cfgAddr[DEV_AW-1:0]] <= devEnt_t'(cfgData[$bits(devEnt_t)-1:0]);
      if (cfgSel == 2'd1) iteTab[cfgAddr] <= iteEnt_t'(cfgData);
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < VPE_N; i++) vpeTab[b][i] <= '0;
      end else if (cfgWe && cfgSel == 2'(2 + b)) begin
        vpeTab[b][cfgAddr[VPE_AW-1:0]] <= vpeEnt_t'(cfgData[$bits(vpeEnt_t)-1:0]);
      end
    end
  end

  always_comb begin
    devCur  = devTab[devQ];
    iteCur  = iteTab[iteIdxQ];
    vpeCur  = vpeTab[sharedQ][vpeIdQ];
    devOk   = devCur.valid && ({1'b0, evtQ} < devCur.count);
    iteOk   = iteCur.valid;
    iteVirt = iteCur.virt;
    vpeOk   = vpeCur.valid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devQ    <= '0;
      evtQ    <= '0;
      sharedQ <= 1'b0;
      iteIdxQ <= '0;
      vpeIdQ  <= '0;
      rspQ    <= '0;
    end else begin
      if (ctl.capReq) begin
        devQ    <= reqDev;
        evtQ    <= reqEvt;
        sharedQ <= reqSharedVpe;
        rspQ    <= '0;
      end
      if (ctl.ldDev) iteIdxQ <= devCur.base + ITE_AW'(evtQ);
      if (ctl.ldIte) begin
        rspQ.virt  <= iteCur.virt;
        rspQ.intid <= iteCur.intid;
        if (iteCur.virt) begin
          vpeIdQ        <= iteCur.tag[VPE_AW-1:0];
          rspQ.vpe      <= iteCur.tag[VPE_AW-1:0];
          rspQ.dbValid  <= iteCur.dbValid;
          rspQ.doorbell <= iteCur.dbValid ? iteCur.doorbell : '0;
        end else begin
          rspQ.coll <= iteCur.tag;
        end
      end
      if (ctl.ldVpe) begin
        rspQ.rd   <= vpeCur.rd;
        rspQ.pend <= vpeCur.pend;
      end
      if (ctl.setErr) begin
        rspQ     <= '0;
        rspQ.err <= 1'b1;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspQ));
  p_err_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspQ.err |-> (rspQ.intid == '0 && rspQ.vpe == '0 && rspQ.coll == '0
                              && !rspQ.virt && !rspQ.dbValid && rspQ.pend == '0));
  p_phys_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspQ.virt |-> (rspQ.rd == '0 && rspQ.pend == '0 && rspQ.doorbell == '0));
  p_no_stray_bell_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspQ.dbValid |-> rspQ.doorbell == '0);
endmodule

// File: rtl/msi_xlate_ctrl.sv
module msi_xlate_ctrl
  import msi_xlate_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  output logic rspValid,
  input  logic rspReady,
  input  logic devOk,
  input  logic iteOk,
  input  logic iteVirt,
  input  logic vpeOk,
  output ctl_t ctl
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    reqReady  = (state == S_IDLE);
    rspValid  = (state == S_RSP);
    unique case (state)
      S_IDLE: if (reqValid) begin
        ctl.capReq = 1'b1;
        nextState  = S_DEV;
      end
      S_DEV: begin
        if (devOk) begin
          ctl.ldDev = 1'b1;
          nextState = S_ITE;
        end else begin
          ctl.setErr = 1'b1;
          nextState  = S_RSP;
        end
      end
      S_ITE: begin
        if (!iteOk) begin
          ctl.setErr = 1'b1;
          nextState  = S_RSP;
        end else begin
          ctl.ldIte = 1'b1;
          nextState = iteVirt ? S_VPE : S_RSP;
        end
      end
      S_VPE: begin
        if (vpeOk) ctl.ldVpe = 1'b1;
        else       ctl.setErr = 1'b1;
        nextState = S_RSP;
      end
      S_RSP: if (rspReady) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  p_single_flight_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  p_rsp_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && reqReady));
  p_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capReq, ctl.ldDev, ctl.ldVpe, ctl.setErr}));
endmodule

// File: rtl/msi_xlate_unit.sv
module msi_xlate_unit
  import msi_xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [DEV_AW-1:0]  reqDev,
  input  logic [EVT_W-1:0]   reqEvt,
  input  logic               reqSharedVpe,
  output logic               rspValid,
  input  logic               rspReady,
  output logic               rspErr,
  output logic               rspVirt,
  output logic [INTID_W-1:0] rspIntid,
  output logic [TAG_W-1:0]   rspColl,
  output logic [VPE_AW-1:0]  rspVpe,
  output logic [RD_W-1:0]    rspRd,
  output logic [PEND_W-1:0]  rspPend,
  output logic               rspDbValid,
  output logic [INTID_W-1:0] rspDoorbell
);
  ctl_t ctl;
  logic devOk, iteOk, iteVirt, vpeOk;
  rsp_t rspQ;

  msi_xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady), .devOk(devOk), .iteOk(iteOk),
    .iteVirt(iteVirt), .vpeOk(vpeOk), .ctl(ctl)
  );

  msi_xlate_data u_data (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .reqDev(reqDev), .reqEvt(reqEvt), .reqSharedVpe(reqSharedVpe),
    .ctl(ctl), .rspValid(rspValid), .rspReady(rspReady), .devOk(devOk), .iteOk(iteOk),
    .iteVirt(iteVirt), .vpeOk(vpeOk), .rspQ(rspQ)
  );

  assign rspErr      = rspQ.err;
  assign rspVirt     = rspQ.virt;
  assign rspIntid    = rspQ.intid;
  assign rspColl     = rspQ.coll;
  assign rspVpe      = rspQ.vpe;
  assign rspRd       = rspQ.rd;
  assign rspPend     = rspQ.pend;
  assign rspDbValid  = rspQ.dbValid;
  assign rspDoorbell = rspQ.doorbell;
endmodule

// File: tb/tb_msi_xlate_unit.sv
module tb_msi_xlate_unit;
  import msi_xlate_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [CFG_AW-1:0] cfgAddr = '0;
  logic [CFG_W-1:0] cfgData = '0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [DEV_AW-1:0] reqDev = '0;
  logic [EVT_W-1:0] reqEvt = '0;
  logic reqSharedVpe = 1'b0;
  logic rspValid;
  logic rspReady = 1'b1;
  logic rspErr, rspVirt, rspDbValid;
  logic [INTID_W-1:0] rspIntid, rspDoorbell;
  logic [TAG_W-1:0] rspColl;
  logic [VPE_AW-1:0] rspVpe;
  logic [RD_W-1:0] rspRd;
  logic [PEND_W-1:0] rspPend;

  always #4 clk = ~clk;

  msi_xlate_unit dut (.*);

  typedef struct {
    rsp_t  r;
    int    lat;
    string req;
  } exp_t;

  exp_t expQ[$];
  devEnt_t devM [DEV_N];
  iteEnt_t iteM [ITE_N];
  vpeEnt_t vpeM [BANKS][VPE_N];
  int checks = 0, errors = 0;
  bit busy = 0, seen = 0, done = 0;
  int cyc = 0;
  rsp_t firstR;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic rsp_t outNow();
    rsp_t r;
    r.err = rspErr; r.virt = rspVirt; r.intid = rspIntid; r.coll = rspColl;
    r.vpe = rspVpe; r.rd = rspRd; r.pend = rspPend; r.dbValid = rspDbValid;
    r.doorbell = rspDoorbell;
    return r;
  endfunction

  function automatic exp_t model(logic [DEV_AW-1:0] d, logic [EVT_W-1:0] e, logic sh, string req);
    exp_t x;
    devEnt_t de;
    iteEnt_t ie;
    vpeEnt_t ve;
    logic [ITE_AW-1:0] idx;
    x.r = '0; x.req = req;
    de = devM[d];
    if (!de.valid || {1'b0, e} >= de.count) begin x.r.err = 1; x.lat = 2; return x; end
    idx = de.base + ITE_AW'(e);
    ie = iteM[idx];
    if (!ie.valid) begin x.r.err = 1; x.lat = 3; return x; end
    if (!ie.virt) begin
      x.r.intid = ie.intid; x.r.coll = ie.tag; x.lat = 3; return x;
    end
    x.lat = 4;
    ve = vpeM[sh][ie.tag[VPE_AW-1:0]];
    if (!ve.valid) begin x.r.err = 1; return x; end
    x.r.virt = 1; x.r.intid = ie.intid; x.r.vpe = ie.tag[VPE_AW-1:0];
    x.r.rd = ve.rd; x.r.pend = ve.pend; x.r.dbValid = ie.dbValid;
    x.r.doorbell = ie.dbValid ? ie.doorbell : '0;
    return x;
  endfunction

  task automatic cfgWrite(logic [1:0] sel, int addr, logic [CFG_W-1:0] data);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgAddr = CFG_AW'(addr); cfgData = data;
    @(negedge clk);
    cfgWe = 0;
    case (sel)
      2'd0: devM[addr] = devEnt_t'(data[$bits(devEnt_t)-1:0]);
      2'd1: iteM[addr] = iteEnt_t'(data);
      default: vpeM[sel-2][addr] = vpeEnt_t'(data[$bits(vpeEnt_t)-1:0]);
    endcase
  endtask

  task automatic startReq(int d, int e, bit sh, string req);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expQ.push_back(model(DEV_AW'(d), EVT_W'(e), sh, req));
    reqDev = DEV_AW'(d); reqEvt = EVT_W'(e); reqSharedVpe = sh; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone();
    while (busy) @(negedge clk);
  endtask

  task automatic lookup(int d, int e, bit sh, string req);
    startReq(d, e, sh, req);
    waitDone();
  endtask

  // Monitor: samples 6 ns after each rising edge, after the negedge drivers.
  initial begin
    forever begin
      @(posedge clk); #6;
      if (rstN) begin
        if (busy) begin
          cyc++;
          chk(reqReady == 0, "R10", "reqReady while busy", 128'(reqReady), 0);
        end
        if (rspValid) begin
          if (expQ.size() == 0) begin
            chk(0, "R10", "unexpected response", 1, 0);
          end else if (!seen) begin
            seen = 1; firstR = outNow();
            chk(cyc == expQ[0].lat, expQ[0].req, "latency", 128'(cyc), 128'(expQ[0].lat));
            chk(outNow() == expQ[0].r, expQ[0].req, "response", 128'(outNow()), 128'(expQ[0].r));
          end else begin
            chk(outNow() == firstR, "R10", "held response", 128'(outNow()), 128'(firstR));
          end
          if (rspReady && expQ.size() != 0) begin
            void'(expQ.pop_front()); busy = 0; seen = 0;
          end
        end
        if (reqValid && reqReady) begin busy = 1; cyc = 0; end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [CFG_W-1:0] devE(bit v, int base, int cnt);
    devEnt_t x; x.valid = v; x.base = ITE_AW'(base); x.count = (EVT_W+1)'(cnt);
    return CFG_W'(x);
  endfunction
  function automatic logic [CFG_W-1:0] iteE(bit v, bit vt, int intid, int tag, bit dbv, int db);
    iteEnt_t x; x.valid = v; x.virt = vt; x.intid = INTID_W'(intid); x.tag = TAG_W'(tag);
    x.dbValid = dbv; x.doorbell = INTID_W'(db);
    return x;
  endfunction
  function automatic logic [CFG_W-1:0] vpeE(bit v, int rd, int pend);
    vpeEnt_t x; x.valid = v; x.rd = RD_W'(rd); x.pend = PEND_W'(pend);
    return CFG_W'(x);
  endfunction

  initial begin
    for (int i = 0; i < DEV_N; i++) devM[i] = '0;
    for (int i = 0; i < ITE_N; i++) iteM[i] = '0;
    for (int b = 0; b < BANKS; b++) for (int i = 0; i < VPE_N; i++) vpeM[b][i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 1, "R1", "reqReady after reset", 128'(reqReady), 1);
    chk(rspValid == 0, "R1", "rspValid after reset", 128'(rspValid), 0);
    lookup(0, 0, 0, "R1");   // tables empty: device invalid

    cfgWrite(0, 0, devE(1, 0, 4));
    cfgWrite(0, 1, devE(1, 8, 16));
    cfgWrite(0, 2, devE(0, 4, 4));
    cfgWrite(0, 3, devE(1, 30, 4));
    cfgWrite(1, 0, iteE(1, 0, 'h1234, 'h5a, 0, 0));
    cfgWrite(1, 1, iteE(1, 1, 'h0040, 2, 1, 'h2000));
    cfgWrite(1, 2, iteE(1, 1, 'h0041, 5, 0, 'h3333));
    cfgWrite(1, 3, iteE(0, 0, 'h0999, 1, 0, 0));
    cfgWrite(1, 8, iteE(1, 0, 'h0abc, 'hc3, 0, 0));
    cfgWrite(1, 9, iteE(1, 1, 'h0077, 7, 1, 'h2100));
    cfgWrite(2, 2, vpeE(1, 3, 'haaaa));
    cfgWrite(2, 5, vpeE(1, 6, 'h1111));
    cfgWrite(3, 2, vpeE(1, 1, 'h5555));
    cfgWrite(3, 7, vpeE(1, 4, 'h7777));

    lookup(0, 0, 0, "R2");      // physical
    lookup(1, 0, 0, "R2");      // physical via base 8
    lookup(0, 1, 0, "R3");      // virtual with doorbell
    lookup(0, 2, 0, "R4");      // virtual, no doorbell
    lookup(0, 1, 1, "R5");      // shared bank for vPE 2
    lookup(1, 1, 1, "R5");      // shared bank vPE 7 valid
    lookup(1, 1, 0, "R9");      // private vPE 7 invalid
    lookup(2, 0, 0, "R6");      // device invalid
    lookup(0, 4, 0, "R7");      // event == count
    lookup(1, 15, 0, "R8");     // in range, slot 23 empty
    lookup(0, 3, 0, "R8");      // invalid translation entry
    lookup(3, 3, 0, "R12");     // 30+3 wraps to slot 1

    // R10: stall the response, outputs must hold, no new request taken
    rspReady = 0;
    startReq(0, 1, 0, "R10");
    while (!rspValid) @(negedge clk);
    repeat (4) @(negedge clk);
    rspReady = 1;
    waitDone();

    // R11: rewrite slot 0 on the edge where the walk latches it
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expQ.push_back(model(0, 0, 0, "R11"));
    reqDev = 0; reqEvt = 0; reqSharedVpe = 0; reqValid = 1;
    @(negedge clk);           // acceptance edge passed
    reqValid = 0;
    @(negedge clk);           // device stage edge passed
    cfgWe = 1; cfgSel = 2'd1; cfgAddr = '0; cfgData = iteE(0, 0, 'h1234, 'h5a, 0, 0);
    @(negedge clk);           // translation latch edge, write lands here too
    cfgWe = 0;
    iteM[0] = iteEnt_t'(iteE(0, 0, 'h1234, 'h5a, 0, 0));
    waitDone();
    lookup(0, 0, 0, "R11");   // now sees the invalid entry

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R10", "pending expectations", 128'(expQ.size()), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule